// File: doc/BRIEF.md
# Array Bound Check Unit

This unit tests a 16-bit register value against a pair of limits kept in memory. A single-cycle start strobe hands it the value, the segment and offset at which the limit pair sits, and the address of the instruction that asked for the check. All four are captured on that strobe. The unit then fetches the two limit words one at a time through a word-wide read port that is handshaked by an acknowledge. It compares both limits with the captured value as unsigned numbers.

When both fetches are done, the unit gives a one-cycle completion pulse. If the value lies outside the limits, a trap flag comes with that pulse. The trap flag carries interrupt vector 5 and a program counter that is rewound to the checking instruction itself, so a handler can restart that instruction. If the value lies within the limits, the pulse comes with no trap and execution goes on.

Top module: `bndchk_unit`

## Requirements
- R1: While reset is asserted, `done_o`, `trap_o` and `mem_req_o` are low.
- R2: The first read after a start uses the captured segment and the captured offset exactly. Its data is taken as the lower limit.
- R3: The second read is issued only after the first has been acknowledged. It uses the same segment and the captured offset plus 2, wrapping modulo 2^16 (0xFFFE gives 0x0000 and 0xFFFF gives 0x0001). Its data is taken as the upper limit.
- R4: A read request stays high, with its segment and offset unchanged, until `mem_ack_i` is seen. Exactly two reads are made for each check.
- R5: `done_o` rises in the cycle right after the clock edge that samples the acknowledge of the upper read. It stays high for exactly one cycle.
- R6: If lower ≤ value ≤ upper, compared as unsigned 16-bit numbers with both ends inclusive, the completion pulse has `trap_o` low. In that case `trap_vec_o` and `trap_pc_o` are 0.
- R7: If value < lower or value > upper (unsigned), the completion pulse has `trap_o` high and `trap_vec_o` equal to 5.
- R8: On a trap, `trap_pc_o` equals the instruction address that was captured at start.
- R9: Changes on `value_i`, `seg_i`, `off_i` and `insn_pc_i` after the start cycle have no effect on the addresses read or on the outcome.
- R10: A start strobe while a check is in progress is dropped. This includes a strobe in the cycle of the completion pulse. A dropped strobe produces no read request afterward.
- R11: `trap_o` is never high outside the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| value_i | input | 16 | Register value to test |
| seg_i | input | 16 | Segment of the limit pair |
| off_i | input | 16 | Offset of the lower limit |
| insn_pc_i | input | 16 | Address of the checking instruction |
| mem_req_o | output | 1 | Read request |
| mem_seg_o | output | 16 | Read segment |
| mem_off_o | output | 16 | Read offset |
| mem_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata_i | input | 16 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Bound violation, only with `done_o` |
| trap_vec_o | output | 8 | Interrupt vector, 5 on trap, else 0 |
| trap_pc_o | output | 16 | Rewound program counter on trap, else 0 |

## Verification
The completion pulse and a new start strobe can fall in the same cycle. At that moment the unit is still busy reporting, and it must drop the strobe instead of beginning another pair of reads. After each check in the sweep, the bench raises `start_i` in exactly the cycle where it sees `done_o`. It then watches `mem_req_o` for several cycles and expects it to stay low. The same cycle also holds the trap decision, so the trap flag, vector and rewound address are judged in that pulse against bounds the bench computes itself.

// File: rtl/bndchk_pkg.sv
package bndchk_pkg;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'd0,
    BC_LOWER  = 2'd1,
    BC_UPPER  = 2'd2,
    BC_REPORT = 2'd3
  } bc_state_e;

  // distance in bytes between the lower and the upper limit word
  localparam int unsigned BC_LIMIT_STRIDE = 2;

endpackage

// File: rtl/bndchk_seq.sv
module bndchk_seq
  import bndchk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  output logic take_start_o,
  output logic take_lo_o,
  output logic take_hi_o,
  output logic req_o,
  output logic upper_phase_o,
  output logic report_o
);

  bc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BC_IDLE:   if (start_i) state_d = BC_LOWER;
      BC_LOWER:  if (ack_i)   state_d = BC_UPPER;
      BC_UPPER:  if (ack_i)   state_d = BC_REPORT;
      BC_REPORT: state_d = BC_IDLE;
      default:   state_d = BC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BC_IDLE;
    else        state_q <= state_d;
  end

  assign take_start_o  = (state_q == BC_IDLE) && start_i;
  assign take_lo_o     = (state_q == BC_LOWER) && ack_i;
  assign take_hi_o     = (state_q == BC_UPPER) && ack_i;
  assign req_o         = (state_q == BC_LOWER) || (state_q == BC_UPPER);
  assign upper_phase_o = (state_q == BC_UPPER);
  assign report_o      = (state_q == BC_REPORT);

endmodule

// File: rtl/bndchk_cmp.sv
module bndchk_cmp #(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] value_i,
  input  logic [WORD_W-1:0] lower_i,
  input  logic [WORD_W-1:0] upper_i,
  output logic              below_o,
  output logic              above_o
);

  // unsigned ordering; equality with either limit is in range
  function automatic logic ult(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    return a < b;
  endfunction

  assign below_o = ult(value_i, lower_i);
  assign above_o = ult(upper_i, value_i);

endmodule

// File: rtl/bndchk_unit.sv
module bndchk_unit #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned SEG_W    = 16,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned PC_W     = 16,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned TRAP_VEC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] value_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [PC_W-1:0]   insn_pc_i,
  output logic              mem_req_o,
  output logic [SEG_W-1:0]  mem_seg_o,
  output logic [OFF_W-1:0]  mem_off_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              trap_o,
  output logic [VEC_W-1:0]  trap_vec_o,
  output logic [PC_W-1:0]   trap_pc_o
);
  import bndchk_pkg::*;

  localparam logic [OFF_W-1:0] STRIDE = OFF_W'(BC_LIMIT_STRIDE);
  localparam logic [VEC_W-1:0] VEC    = VEC_W'(TRAP_VEC);

  // offset of the upper limit word; wraps inside the segment
  function automatic logic [OFF_W-1:0] upper_off(input logic [OFF_W-1:0] base);
    return base + STRIDE;
  endfunction

  // named internal events, also used by the bound checker
  logic take_start, take_lo, take_hi, upper_phase, report;
  logic below, above, violation;

  logic [WORD_W-1:0] val_q, lo_q, hi_q;
  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic [PC_W-1:0]   pc_q;

  bndchk_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .ack_i        (mem_ack_i),
    .take_start_o (take_start),
    .take_lo_o    (take_lo),
    .take_hi_o    (take_hi),
    .req_o        (mem_req_o),
    .upper_phase_o(upper_phase),
    .report_o     (report)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      seg_q <= '0;
      off_q <= '0;
      pc_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      if (take_start) begin
        val_q <= value_i;
        seg_q <= seg_i;
        off_q <= off_i;
        pc_q  <= insn_pc_i;
      end
      if (take_lo) lo_q <= mem_rdata_i;
      if (take_hi) hi_q <= mem_rdata_i;
    end
  end

  bndchk_cmp #(.WORD_W(WORD_W)) u_cmp (
    .value_i(val_q),
    .lower_i(lo_q),
    .upper_i(hi_q),
    .below_o(below),
    .above_o(above)
  );

  assign violation  = below || above;

  assign mem_seg_o  = seg_q;
  assign mem_off_o  = upper_phase ? upper_off(off_q) : off_q;

  assign done_o     = report;
  assign trap_o     = report && violation;
  assign trap_vec_o = trap_o ? VEC  : '0;
  assign trap_pc_o  = trap_o ? pc_q : '0;

endmodule

// File: rtl/bndchk_sva.sv
module bndchk_sva #(
  parameter int unsigned SEG_W    = 16,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned TRAP_VEC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             mem_req_o,
  input logic [SEG_W-1:0] mem_seg_o,
  input logic [OFF_W-1:0] mem_off_o,
  input logic             mem_ack_i,
  input logic             done_o,
  input logic             trap_o,
  input logic [VEC_W-1:0] trap_vec_o,
  input logic             take_lo,
  input logic             take_hi
);

  localparam logic [OFF_W-1:0] STEP = OFF_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!done_o && !trap_o && !mem_req_o)
        else $error("R1 outputs active in reset");
    end
  end

  p_upper_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_lo |=> (mem_req_o && mem_off_o == OFF_W'($past(mem_off_o) + STEP)
                 && mem_seg_o == $past(mem_seg_o)))
    else $error("R3 upper read address");

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_off_o) && $stable(mem_seg_o)))
    else $error("R4 request dropped or moved");

  p_done_after_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_hi |=> done_o)
    else $error("R5 done latency");

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("R5 done longer than a cycle");

  p_trap_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (trap_vec_o == VEC_W'(TRAP_VEC)))
    else $error("R7 trap vector");

  p_start_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> !mem_req_o)
    else $error("R10 start during report accepted");

  p_trap_in_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> done_o)
    else $error("R11 trap outside completion");

endmodule

bind bndchk_unit bndchk_sva #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .mem_req_o (mem_req_o),
  .mem_seg_o (mem_seg_o),
  .mem_off_o (mem_off_o),
  .mem_ack_i (mem_ack_i),
  .done_o    (done_o),
  .trap_o    (trap_o),
  .trap_vec_o(trap_vec_o),
  .take_lo   (take_lo),
  .take_hi   (take_hi)
);

// File: tb/bndchk_unit_test.sv
`timescale 1ns/1ps
module bndchk_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] value_i = '0, seg_i = '0, off_i = '0, insn_pc_i = '0;
  logic        mem_req_o, mem_ack_i = 1'b0;
  logic [15:0] mem_seg_o, mem_off_o, mem_rdata_i = '0;
  logic        done_o, trap_o;
  logic [7:0]  trap_vec_o;
  logic [15:0] trap_pc_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  bndchk_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
    .seg_i(seg_i), .off_i(off_i), .insn_pc_i(insn_pc_i),
    .mem_req_o(mem_req_o), .mem_seg_o(mem_seg_o), .mem_off_o(mem_off_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .trap_o(trap_o), .trap_vec_o(trap_vec_o), .trap_pc_o(trap_pc_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_outside(input logic [15:0] v, input logic [15:0] lo, input logic [15:0] hi);
    return (int'(v) < int'(lo)) || (int'(v) > int'(hi));
  endfunction

  task automatic run_case(input logic [15:0] v, input logic [15:0] lo, input logic [15:0] hi,
                          input logic [15:0] off, input logic [15:0] seg, input logic [15:0] pc,
                          input int delay);
    logic [15:0] addr[2];
    logic [15:0] hi_off;
    int nreads = 0, w = 0, hi_cyc = -1, cyc = 0;
    bit seen_done = 0, seg_ok = 1, hold_ok = 1;
    bit exp_trap;
    hi_off = off + 16'd2;
    exp_trap = ref_outside(v, lo, hi);
    @(negedge clk);
    value_i = v; seg_i = seg; off_i = off; insn_pc_i = pc; start_i = 1'b1;
    for (int k = 0; k < 40 && !seen_done; k++) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0; mem_ack_i = 1'b0;
      value_i = ~v; seg_i = ~seg; off_i = off ^ 16'h00F0; insn_pc_i = ~pc;  // R9 disturbance
      if (trap_o && !done_o) hold_ok = 0;
      if (done_o) begin
        seen_done = 1;
        check(nreads == 2, "R4 read count", nreads, 2);
        check(addr[0] == off, "R2 lower offset", addr[0], off);
        check(addr[1] == hi_off, "R3 upper offset wrap", addr[1], hi_off);
        check(seg_ok, "R9 segment kept", 0, 1);
        check(cyc == hi_cyc + 1, "R5 done latency", cyc, hi_cyc + 1);
        check(trap_o == exp_trap, exp_trap ? "R7 trap" : "R6 no trap", trap_o, exp_trap);
        if (exp_trap) begin
          check(trap_vec_o == 8'd5, "R7 vector", trap_vec_o, 5);
          check(trap_pc_o == pc, "R8 rewound pc", trap_pc_o, pc);
        end else begin
          check(trap_vec_o == 0 && trap_pc_o == 0, "R6 quiet vector", {trap_vec_o, trap_pc_o}, 0);
        end
        start_i = 1'b1;  // R10: strobe in the completion cycle
      end else if (mem_req_o) begin
        if (mem_seg_o != seg) seg_ok = 0;
        if (w >= delay) begin
          if (nreads < 2) addr[nreads] = mem_off_o;
          mem_ack_i = 1'b1;
          mem_rdata_i = (mem_off_o == off) ? lo : (mem_off_o == hi_off) ? hi : 16'hDEAD;
          nreads++;
          if (nreads == 2) hi_cyc = cyc;
          w = 0;
        end else w++;
      end
    end
    check(seen_done, "R5 done seen", seen_done, 1);
    check(hold_ok, "R11 trap only with done", 0, 1);
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o, "R5 single pulse", done_o, 0);
    for (int k = 0; k < 3; k++) begin
      check(!mem_req_o, "R10 dropped start", mem_req_o, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] pts[7];
    logic [15:0] offs[3];
    int idx = 0;
    pts = '{16'h0000, 16'h0001, 16'h0007, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
    offs = '{16'h0010, 16'hFFFE, 16'hFFFF};
    repeat (3) @(negedge clk);
    check(!done_o && !trap_o && !mem_req_o, "R1 reset quiet", {done_o, trap_o, mem_req_o}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 7; c++) begin
          run_case(pts[a], pts[b], pts[c], offs[idx % 3], 16'h1234 ^ 16'(idx),
                   16'h0400 + 16'(idx * 3), idx % 3);
          idx++;
        end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule